// File: doc/BRIEF.md
# Block summation engine for a word-addressed RAM

This block adds up a run of consecutive words held in a synchronous RAM. A start pulse captures a start address into an internal base register and a word count into a down-counter. The engine then issues one read per cycle at rising addresses. Each returned 6-bit value is added into a 12-bit accumulator. When the last value has been added, the engine raises a done flag, and a zero flag if the total is zero.

The RAM has 1024 locations. Its read data appears one clock after a read is issued. If the window runs past the top location, the address continues from location 0. The accumulator is wide enough for the largest count of 63-valued words, so it never overflows. The result and the flags hold until the next accepted start.

Top module: `blksum_top`

## Requirements
- R1: While reset is held and directly after it: `ram_re_o`, `busy_o`, `done_o` and `zero_o` are 0, and `acc_o` is 0.
- R2: A start accepted while not busy takes its address from `base_i`. The first read is issued at that address in the cycle after the start edge.
- R3: After a start with count n, `ram_re_o` is high for exactly n consecutive cycles. The address rises by one in each of those cycles.
- R4: The read address continues from 0 after 1023, so the window wraps around the end of memory.
- R5: When done, `acc_o` equals the sum of the n words read. The sum is zero-extended, and the accumulator never overflows.
- R6: `done_o` rises exactly n+2 clock edges after the start edge, counting the start edge itself. For n = 0 it rises after 1 edge. It then holds, with `acc_o` unchanged, until the next start.
- R7: `zero_o` is 1 exactly when `done_o` is 1 and the accumulated total is 0.
- R8: An accepted start clears the accumulator before the first value is added. Changes on `start_i`, `base_i` and `count_i` while busy have no effect on the run.
- R9: A count of 0 issues no read and reaches done with `acc_o` = 0 and `zero_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| base_i | input | 10 | Start address, captured into the base register on start |
| count_i | input | 6 | Number of words to add (n) |
| ram_addr_o | output | 10 | RAM read address |
| ram_re_o | output | 1 | RAM read enable |
| ram_data_i | input | 6 | RAM read data, one cycle after the read |
| acc_o | output | 12 | Accumulator |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished; result valid |
| zero_o | output | 1 | Finished with a zero total |

## Verification
The hardest case to reach from the ports is a start that arrives mid-run with a different base and count, because it must be ignored. The stimulus reaches it by pulsing `start_i` two cycles into a run while also changing `base_i` and `count_i`. The addresses and final total must still match the original window. Wrap-around is reached by placing the window at 1020 so that it crosses 1023. A full 63-word window over a region filled with 63 exercises the top of the accumulator range. A window over a zero-filled region, and a zero count, exercise the zero flag.

// File: rtl/blksum_pkg.sv
package blksum_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } bs_state_e;
endpackage

// File: rtl/blksum_rst_sync.sv
module blksum_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/blksum_ctrl.sv
module blksum_ctrl
  import blksum_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output bs_state_e        state_o,
  output logic             load_o,
  output logic             issue_o
);
  bs_state_e        state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             rem_en;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    rem_en  = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          load_o  = 1'b1;
          rem_en  = 1'b1;
          rem_d   = count_i;
          state_d = (count_i == '0) ? ST_DONE : ST_RUN;
        end
      end
      ST_RUN: begin
        rem_en = 1'b1;
        rem_d  = rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) state_d = ST_DRAIN;
      end
      ST_DRAIN: state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      if (rem_en) rem_q <= rem_d;
    end
  end

  assign state_o = state_q;
  assign issue_o = (state_q == ST_RUN);
endmodule

// File: rtl/blksum_addr.sv
module blksum_addr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = load_i | step_i;
    addr_d  = load_i ? base_i : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/blksum_acc.sv
module blksum_acc #(
  parameter int DATA_W = 6,
  parameter int ACC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              issue_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic             vld_q;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             acc_en;

  always_comb begin
    acc_en = clr_i | vld_q;
    acc_d  = clr_i ? '0 : acc_q + ACC_W'(data_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= '0;
    end else begin
      vld_q <= issue_i;
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/blksum_top.sv
module blksum_top
  import blksum_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 6,
  parameter int CNT_W  = 6,
  localparam int ACC_W = DATA_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_re_o,
  input  logic [DATA_W-1:0] ram_data_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              zero_o
);
  logic      rst_int_n;
  bs_state_e state;
  logic      load, issue;

  blksum_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  blksum_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .count_i(count_i),
    .state_o(state), .load_o(load), .issue_o(issue)
  );

  blksum_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .load_i(load), .base_i(base_i),
    .step_i(issue), .addr_o(ram_addr_o)
  );

  blksum_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_int_n), .clr_i(load), .issue_i(issue),
    .data_i(ram_data_i), .acc_o(acc_o)
  );

  assign ram_re_o = issue;
  assign busy_o   = (state == ST_RUN) || (state == ST_DRAIN);
  assign done_o   = (state == ST_DONE);
  assign zero_o   = done_o && (acc_o == '0);
endmodule

// File: rtl/blksum_chk.sv
module blksum_chk #(
  parameter int ADDR_W = 10,
  parameter int ACC_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_re_o,
  input logic [ACC_W-1:0]  acc_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              zero_o
);
  AST_READ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re_o |-> busy_o); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re_o && $past(ram_re_o)) |-> ram_addr_o == ADDR_W'($past(ram_addr_o) + 1'b1)); // R4
  AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R6
  AST_ZERO_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> (done_o && acc_o == '0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> acc_o >= $past(acc_o)); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> acc_o == '0); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(acc_o))); // R6
endmodule

bind blksum_top blksum_chk #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ram_addr_o(ram_addr_o),
  .ram_re_o(ram_re_o), .acc_o(acc_o), .busy_o(busy_o), .done_o(done_o),
  .zero_o(zero_o)
);

// File: tb/tb_blksum_top.sv
module tb_blksum_top;
  localparam int AW = 10;
  localparam int DW = 6;
  localparam int CW = 6;
  localparam int MEM_N = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [CW-1:0] count_i = '0;
  logic [AW-1:0] ram_addr_o;
  logic          ram_re_o;
  logic [DW-1:0] ram_data_i;
  logic [11:0]   acc_o;
  logic          busy_o, done_o, zero_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [DW-1:0] mem [MEM_N];

  always #2 clk = ~clk;

  blksum_top dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .count_i(count_i), .ram_addr_o(ram_addr_o), .ram_re_o(ram_re_o),
    .ram_data_i(ram_data_i), .acc_o(acc_o), .busy_o(busy_o),
    .done_o(done_o), .zero_o(zero_o)
  );

  always_ff @(posedge clk) if (ram_re_o) ram_data_i <= mem[ram_addr_o];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic logic [DW-1:0] pattern(int a);
    if (a >= 100 && a < 110) return '0;
    if (a >= 200 && a < 263) return 6'd63;
    return DW'((a * 37 + 11) % 64);
  endfunction

  function automatic int ref_sum(int b, int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += int'(pattern((b + i) % MEM_N));
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One run: start at a negedge, then watch outputs at every negedge
  task automatic run(input int b, input int n, input bit glitch);
    int cycles, reads, exp_sum, exp_cyc;
    bit addr_ok;
    int bad_addr;
    @(negedge clk);
    start_i = 1'b1; base_i = AW'(b); count_i = CW'(n);
    @(negedge clk);
    start_i = 1'b0; base_i = AW'(b + 333); count_i = CW'(n + 7);
    chk(acc_o == 0, "R8 cleared", int'(acc_o), 0);
    cycles = 1; reads = 0; addr_ok = 1'b1; bad_addr = 0;
    while (!done_o && cycles < 200) begin
      if (ram_re_o) begin
        if (ram_addr_o != AW'((b + reads) % MEM_N)) begin
          addr_ok = 1'b0; bad_addr = int'(ram_addr_o);
        end
        reads++;
      end
      if (glitch && cycles == 2) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cycles++;
    end
    exp_sum = ref_sum(b, n);
    exp_cyc = (n == 0) ? 1 : n + 2;
    chk(addr_ok, "R2/R3/R4 address", bad_addr, (b + reads) % MEM_N);
    chk(reads == n, "R3 read count", reads, n);
    chk(cycles == exp_cyc, "R6 latency", cycles, exp_cyc);
    chk(int'(acc_o) == exp_sum, "R5 sum", int'(acc_o), exp_sum);
    chk(zero_o == (exp_sum == 0), "R7 zero", int'(zero_o), int'(exp_sum == 0));
    repeat (3) @(negedge clk);
    chk(done_o && int'(acc_o) == exp_sum, "R6 hold", int'(acc_o), exp_sum);
  endtask

  // base, count, mid-run start pulse
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {10'd0,    6'd35, 1'b0},
    {10'd517,  6'd5,  1'b0},
    {10'd1020, 6'd10, 1'b0},   // wraps past 1023: R4
    {10'd200,  6'd63, 1'b0},   // full range: R5
    {10'd100,  6'd10, 1'b0},   // zero total: R7
    {10'd40,   6'd20, 1'b1},   // start while busy: R8
    {10'd1023, 6'd2,  1'b1},
    {10'd700,  6'd1,  1'b0}
  };

  initial begin
    for (int a = 0; a < MEM_N; a++) mem[a] = pattern(a);
    repeat (3) @(negedge clk);
    chk(!ram_re_o && !busy_o && !done_o && !zero_o && acc_o == 0,
        "R1 reset", int'(acc_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && acc_o == 0, "R1 after release", int'(busy_o), 0);

    for (int v = 0; v < NV; v++)
      run(int'(VEC[v][16:7]), int'(VEC[v][6:1]), VEC[v][0]);

    // R9: zero count after a nonzero result
    run(300, 0, 1'b0);
    chk(zero_o == 1'b1, "R9 zero count", int'(zero_o), 1);

    // R1: reset in the middle of a run
    @(negedge clk);
    start_i = 1'b1; base_i = 10'd10; count_i = 6'd30;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy_o && !ram_re_o && !done_o && acc_o == 0, "R1 mid-run reset",
        int'(acc_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run(1000, 30, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule